// File: doc/BRIEF.md
# Core Clock Divider and Source Switch

This block derives the core clock enable from a 10.24 MHz master clock. A 3-bit divide field picks a power-of-two ratio, so the core sees one enable pulse every 2^N base ticks. Out of reset the ratio is 8, which gives a 1.28 MHz core rate. A setting of zero gives an enable on every base tick, which is the full master rate.

The block also chooses the clock source: the internal oscillator, an external crystal or an external clock pin. Software never switches the source directly. It selects the new source and then asks for nap. The request is captured on entry to nap, and the core enable stays low for the whole nap. When the wake interrupt (from a timer set longer than 120 µs) ends the nap, the new source is already active. The external pin runs faster than needed and is halved internally before it feeds the divider.

Top module: `ccs_top`

## Requirements
- R1: While awake, `coreEn` is a one-cycle pulse issued on the last of every 2^N base ticks, where N is the divider value in use.
- R2: Reset sets N to 3, `napOn` to 0, `activeSrc` to 0 and `coreEn` to 0. With the master clock as the base, the first `coreEn` falls in the 8th cycle after reset is released.
- R3: With N equal to 0, `coreEn` is high on every base tick.
- R4: A new `divSel` value is taken into use only in a cycle where `coreEn` is high (the end of a period) or during nap. A period already running keeps its length.
- R5: When `activeSrc` is 2 (the external pin), only every second `extClkEn` pulse counts as a base tick, starting with the second pulse after nap exit. For sources 0 and 1, every master cycle is a base tick.
- R6: `napReq` high in an awake cycle sets `napOn` in the next cycle. `coreEn` stays 0 in every cycle in which `napOn` is 1.
- R7: `napOn` stays high until a cycle with `wakeIrq` high, and it clears in the next cycle. `wakeIrq` has no effect while awake, and `napReq` has no effect while in nap.
- R8: Source encoding: 0 is the internal oscillator, 1 the crystal, 2 the external pin, and 3 is reserved. `srcReq` is sampled only in the cycle that enters nap, and it becomes `activeSrc` at nap exit. A reserved request keeps the current source. `activeSrc` never changes outside a nap exit.
- R9: At nap exit the divide count starts again from zero. N is taken from `divSel` as it stood in the last nap cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 10.24 MHz master clock |
| rstN | input | 1 | Active-low synchronous reset |
| divSel | input | 3 | Requested divide exponent N |
| srcReq | input | 2 | Requested clock source, applied through nap |
| napReq | input | 1 | Request to enter nap |
| wakeIrq | input | 1 | Timer interrupt that ends nap |
| extClkEn | input | 1 | One-cycle pulse per edge of the external clock pin |
| coreEn | output | 1 | Core clock enable |
| napOn | output | 1 | High while in nap |
| activeSrc | output | 2 | Clock source now in use |

## Verification
The divider is exercised at exponents 0, 2, 3 and 5. Changes to `divSel` are made in the middle of a period, which separates a deferred load from an immediate one. Source requests are made both while awake and across a nap. This shows that only a nap exit moves `activeSrc`, and that the reserved code 3 is absorbed. After the switch to the external pin, a sparse `extClkEn` pattern shows whether the halving is applied before the divider. Spurious wake and nap pulses show whether the state machine ignores them in the wrong state.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef enum logic [1:0] {
    SRC_OSC    = 2'd0,
    SRC_XTAL   = 2'd1,
    SRC_EXTPIN = 2'd2
  } srcSel_e;

  // strobes from control to the divider path
  typedef struct packed {
    logic hold;    // nap: freeze output, clear count, reload divider
    logic useExt;  // base tick comes from the halved external pin
  } ccsCtl_t;
endpackage

// File: rtl/ccs_ctrl.sv
module ccs_ctrl
  import ccs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] srcReq,
  input  logic       napReq,
  input  logic       wakeIrq,
  output ccsCtl_t    ctl,
  output logic       napOn,
  output logic [1:0] activeSrc
);
  srcSel_e curSrc, pendSrc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      napOn   <= 1'b0;
      curSrc  <= SRC_OSC;
      pendSrc <= SRC_OSC;
    end else if (napOn) begin
      if (wakeIrq) begin
        napOn  <= 1'b0;
        curSrc <= pendSrc;
      end
    end else if (napReq) begin
      napOn   <= 1'b1;
      pendSrc <= (srcReq == 2'd3) ? curSrc : srcSel_e'(srcReq);
    end
  end

  assign activeSrc  = curSrc;
  assign ctl.hold   = napOn;
  assign ctl.useExt = (curSrc == SRC_EXTPIN);

  // R8: the source moves only on a nap exit
  p_src_on_wake_r8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(activeSrc) |-> ($past(napOn) && $past(wakeIrq)))
    else $error("activeSrc changed outside nap exit");

  // R7: nap persists until woken
  p_nap_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (napOn && !wakeIrq) |=> napOn)
    else $error("nap left without wake");

  // R6: nap request while awake enters nap
  p_nap_enter_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!napOn && napReq) |=> napOn)
    else $error("nap not entered");

  // R8: reserved code never becomes active
  p_src_legal_r8: assert property (@(posedge clk) disable iff (!rstN)
    activeSrc != 2'd3)
    else $error("reserved source active");
endmodule

// File: rtl/ccs_divpath.sv
module ccs_divpath
  import ccs_pkg::*;
#(
  parameter int DIV_W     = 3,
  parameter int RESET_DIV = 3,
  parameter bit EXT_HALVE = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  ccsCtl_t          ctl,
  input  logic [DIV_W-1:0] divSel,
  input  logic             extClkEn,
  output logic             coreEn
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [DIV_W-1:0] curDiv;
  logic [CNT_W-1:0] cnt, lastCnt;
  logic             extTick, baseTick, atEnd;

  generate
    if (EXT_HALVE) begin : g_halve
      logic phase;
      always_ff @(posedge clk) begin
        if (!rstN || ctl.hold) phase <= 1'b0;
        else if (ctl.useExt && extClkEn) phase <= ~phase;
      end
      assign extTick = extClkEn && phase;
    end else begin : g_direct
      assign extTick = extClkEn;
    end
  endgenerate

  assign baseTick = ctl.useExt ? extTick : 1'b1;
  assign lastCnt  = (CNT_W'(1) << curDiv) - CNT_W'(1);
  assign atEnd    = baseTick && (cnt == lastCnt);
  assign coreEn   = !ctl.hold && atEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      curDiv <= DIV_W'(RESET_DIV);
    end else if (ctl.hold) begin
      cnt    <= '0;
      curDiv <= divSel;
    end else if (atEnd) begin
      cnt    <= '0;
      curDiv <= divSel;
    end else if (baseTick) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  // R4: divider only reloads at a period end or during nap
  p_div_defer_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!coreEn && !ctl.hold) |=> $stable(curDiv))
    else $error("divider changed mid-period");

  // R1: count stays inside the period
  p_cnt_range_r1: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lastCnt)
    else $error("count beyond period");

  // R6: no enable while held
  p_quiet_nap_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.hold |-> !coreEn)
    else $error("enable during nap");
endmodule

// File: rtl/ccs_top.sv
module ccs_top
  import ccs_pkg::*;
#(
  parameter int DIV_W     = 3,
  parameter int RESET_DIV = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divSel,
  input  logic [1:0]       srcReq,
  input  logic             napReq,
  input  logic             wakeIrq,
  input  logic             extClkEn,
  output logic             coreEn,
  output logic             napOn,
  output logic [1:0]       activeSrc
);
  ccsCtl_t ctl;

  ccs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .srcReq(srcReq), .napReq(napReq),
    .wakeIrq(wakeIrq), .ctl(ctl), .napOn(napOn), .activeSrc(activeSrc)
  );

  ccs_divpath #(.DIV_W(DIV_W), .RESET_DIV(RESET_DIV), .EXT_HALVE(1'b1)) u_div (
    .clk(clk), .rstN(rstN), .ctl(ctl), .divSel(divSel),
    .extClkEn(extClkEn), .coreEn(coreEn)
  );
endmodule

// File: tb/tb_ccs_top.sv
module tb_ccs_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] divSel = 3'd3;
  logic [1:0] srcReq = 2'd0;
  logic napReq = 1'b0, wakeIrq = 1'b0, extClkEn = 1'b0;
  logic coreEn, napOn;
  logic [1:0] activeSrc;

  int total = 0, bad = 0;
  bit finished = 0;
  int extGap = 0;  // 0: ext pin idle, else pulse every extGap cycles
  int cyc = 0;

  // behavioural reference state
  int mNap = 0, mSrc = 0, mPend = 0, mDiv = 3, mCnt = 0, mPhase = 0;

  always #10 clk = ~clk;  // 50 MHz

  ccs_top dut (
    .clk(clk), .rstN(rstN), .divSel(divSel), .srcReq(srcReq),
    .napReq(napReq), .wakeIrq(wakeIrq), .extClkEn(extClkEn),
    .coreEn(coreEn), .napOn(napOn), .activeSrc(activeSrc)
  );

  task automatic check(string tag, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d cycle=%0d", tag, what, act, exp, cyc);
    end
  endtask

  function automatic int baseNow();
    if (mSrc == 2) return (extClkEn && mPhase == 1) ? 1 : 0;
    return 1;
  endfunction

  // one cycle: drive inputs (already set), compare, advance the model
  task automatic step(string tag);
    int b, expEn;
    extClkEn = (extGap != 0) && (cyc % extGap == 0);
    #1;
    b = baseNow();
    expEn = (mNap == 0 && b == 1 && mCnt == (1 << mDiv) - 1) ? 1 : 0;
    check(tag, "coreEn", int'(coreEn), expEn);
    check(tag, "napOn", int'(napOn), mNap);
    check(tag, "activeSrc", int'(activeSrc), mSrc);
    @(posedge clk);
    if (mNap == 1) begin
      mCnt = 0; mPhase = 0; mDiv = int'(divSel);
      if (wakeIrq) begin mNap = 0; mSrc = mPend; end
    end else begin
      if (mSrc == 2 && extClkEn) mPhase = 1 - mPhase;
      if (expEn == 1) begin mCnt = 0; mDiv = int'(divSel); end
      else if (b == 1) mCnt++;
      if (napReq) begin
        mNap = 1;
        mPend = (srcReq == 2'd3) ? mSrc : int'(srcReq);
      end
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic run(string tag, int n);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic napCycle(string tag, logic [1:0] src, int napLen);
    srcReq = src; napReq = 1'b1; step(tag);
    napReq = 1'b0; srcReq = 2'd0;
    run(tag, napLen);
    wakeIrq = 1'b1; step(tag);
    wakeIrq = 1'b0;
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    #1;
    // R2: reset state
    check("R2", "coreEn@reset", int'(coreEn), 0);
    check("R2", "napOn@reset", int'(napOn), 0);
    check("R2", "activeSrc@reset", int'(activeSrc), 0);
    @(negedge clk);
    rstN = 1'b1;
    run("R2", 20);
    divSel = 3'd0; run("R4", 5);        // mid-period change
    run("R3", 20);
    divSel = 3'd2; run("R1", 30);
    divSel = 3'd5; run("R1", 100);
    srcReq = 2'd1; run("R8", 10);       // awake request: no effect
    srcReq = 2'd0;
    wakeIrq = 1'b1; run("R7", 3);       // wake while awake: no effect
    wakeIrq = 1'b0;
    divSel = 3'd1;
    srcReq = 2'd1; napReq = 1'b1; step("R6");
    napReq = 1'b0; srcReq = 2'd0;
    run("R6", 10);
    napReq = 1'b1; run("R7", 5);        // nap request while napping
    napReq = 1'b0; run("R7", 30);
    wakeIrq = 1'b1; step("R7"); wakeIrq = 1'b0;
    run("R9", 20);
    extGap = 3;
    napCycle("R5", 2'd2, 15);
    run("R5", 80);
    divSel = 3'd2; run("R5", 60);
    napCycle("R8", 2'd3, 8);            // reserved: stay on ext pin
    run("R8", 40);
    extGap = 0;
    divSel = 3'd3;
    napCycle("R9", 2'd0, 12);
    run("R9", 40);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule